// File: doc/BRIEF.md
# Indirect Register Access Window

This block lets a host that decodes only a 256-byte aperture reach every word of a 512 KB internal register space. Two registers sit inside the aperture: a pointer register and a data port. The host first writes the internal byte address it wants into the pointer. Each later read or write of the data port is then carried out on the internal register bus at that address. The pointer keeps its value until the host rewrites it, so a run of data-port accesses all reach the same internal register.

Every other word offset in the aperture goes straight through to the internal bus. Its internal address is a fixed base plus the host offset. In the internal map, the aperture is a small, fixed slice of registers near a chosen base. The internal register file, and whatever host protocol drives the host strobes, belong to other blocks.

Accesses are 32 bits wide and word aligned. Internal strobes follow the host strobes combinationally in the same cycle. Read data comes back through one register.

Top module: `iwin_top`

## Requirements
- R1: A host write to the pointer offset (byte 0x40) loads host_wdata[18:0] into the pointer with bits 1:0 forced to zero, and ignores bits 31:19. No access to the pointer offset raises int_wr or int_rd.
- R2: After reset the pointer holds zero, and host_rdata is zero.
- R3: A host write to the data-port offset (byte 0x44) raises int_wr for exactly that cycle. In that cycle int_addr equals the pointer and int_wdata equals host_wdata.
- R4: A host read of the data-port offset raises int_rd in the same cycle at the pointer address. From the next cycle, host_rdata shows the int_rdata of the strobe cycle.
- R5: The pointer keeps its value across any number of data-port accesses. A pointer write redirects a data-port access made in the very next cycle.
- R6: Any other host offset is a direct access. Its internal address is 0x50000 plus host_addr with bits 1:0 cleared. Direct reads and writes have the same strobe and return timing as data-port accesses.
- R7: host_rdata changes only after a host read. Otherwise it holds its last value.
- R8: When host_wr and host_rd are both high, the access is a write only. No int_rd is raised and host_rdata keeps its value.
- R9: A host read of the pointer offset returns the pointer, zero-extended to 32 bits, in the next cycle.
- R10: int_wr and int_rd are never high together, and neither is ever high without a host strobe in the same cycle.

Host offsets in R1, R3 and R6 are compared with bits 1:0 ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 8 | Byte offset within the aperture |
| host_wdata | input | 32 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_rdata | output | 32 | Read result, valid the cycle after host_rd |
| int_addr | output | 19 | Internal byte address |
| int_wdata | output | 32 | Internal write data |
| int_wr | output | 1 | Internal write strobe |
| int_rd | output | 1 | Internal read strobe |
| int_rdata | input | 32 | Internal read data, valid in the int_rd cycle |

## Verification
Internal strobes, address and write data are due in the same cycle as the host strobe. The bench therefore drives each access at the falling edge and samples the internal bus one time unit later, before the rising edge that ends the access. host_rdata is registered once, so it is sampled at the next falling edge after the access. The pointer takes effect at that same edge, which is what lets a data access in the next cycle already see the new target. The bench's internal-bus model returns an arithmetic function of int_addr. Every expected read value is then computed from the address the bench itself programmed.

// File: rtl/iwin_pkg.sv
package iwin_pkg;

    // Which aperture resource a host access selects
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_PTR    = 2'd1,
        SEL_PORT   = 2'd2,
        SEL_DIRECT = 2'd3
    } win_sel_e;

endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
    import iwin_pkg::*;
#(
    parameter int unsigned HOST_AW = 8,
    parameter logic [HOST_AW-1:0] PTR_OFS  = 8'h40,
    parameter logic [HOST_AW-1:0] PORT_OFS = 8'h44
) (
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_wr,
    input  logic               host_rd,
    output win_sel_e           sel,
    output logic               acc_wr,
    output logic               acc_rd
);

    localparam logic [HOST_AW-1:0] WORD_MASK = ~HOST_AW'(3);

    logic [HOST_AW-1:0] word_addr;

    always_comb begin
        word_addr = host_addr & WORD_MASK;
        acc_wr    = host_wr;
        acc_rd    = host_rd && !host_wr;   // write wins a collision
        if (!(host_wr || host_rd)) begin
            sel = SEL_NONE;
        end else if (word_addr == (PTR_OFS & WORD_MASK)) begin
            sel = SEL_PTR;
        end else if (word_addr == (PORT_OFS & WORD_MASK)) begin
            sel = SEL_PORT;
        end else begin
            sel = SEL_DIRECT;
        end
    end

endmodule

// File: rtl/iwin_route.sv
module iwin_route
    import iwin_pkg::*;
#(
    parameter int unsigned HOST_AW = 8,
    parameter int unsigned INT_AW  = 19,
    parameter int unsigned DW      = 32,
    parameter logic [INT_AW-1:0] DIRECT_BASE = 19'h50000
) (
    input  win_sel_e           sel,
    input  logic               acc_wr,
    input  logic               acc_rd,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    input  logic [INT_AW-1:0]  ptr,
    output logic [INT_AW-1:0]  int_addr,
    output logic [DW-1:0]      int_wdata,
    output logic               int_wr,
    output logic               int_rd
);

    localparam int unsigned   PADW      = INT_AW - HOST_AW;
    localparam logic [INT_AW-1:0] BASE_AL = DIRECT_BASE & ~INT_AW'(3);

    logic               reaches_int;
    logic [INT_AW-1:0]  direct_addr;

    always_comb begin
        reaches_int = (sel == SEL_PORT) || (sel == SEL_DIRECT);
        direct_addr = BASE_AL + {{PADW{1'b0}}, host_addr & ~HOST_AW'(3)};
        int_addr    = (sel == SEL_DIRECT) ? direct_addr : ptr;
        int_wdata   = host_wdata;
        int_wr      = reaches_int && acc_wr;
        int_rd      = reaches_int && acc_rd;
    end

endmodule

// File: rtl/iwin_top.sv
module iwin_top
    import iwin_pkg::*;
#(
    parameter int unsigned HOST_AW = 8,
    parameter int unsigned INT_AW  = 19,
    parameter int unsigned DW      = 32,
    parameter logic [HOST_AW-1:0] PTR_OFS  = 8'h40,
    parameter logic [HOST_AW-1:0] PORT_OFS = 8'h44,
    parameter logic [INT_AW-1:0]  DIRECT_BASE = 19'h50000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [DW-1:0]      host_wdata,
    input  logic               host_wr,
    input  logic               host_rd,
    output logic [DW-1:0]      host_rdata,
    output logic [INT_AW-1:0]  int_addr,
    output logic [DW-1:0]      int_wdata,
    output logic               int_wr,
    output logic               int_rd,
    input  logic [DW-1:0]      int_rdata
);

    localparam int unsigned RPAD = DW - INT_AW;

    typedef struct packed {
        logic [INT_AW-1:0] ptr;
        logic [DW-1:0]     rdata;
    } win_state_t;

    win_state_t st_d, st_q;
    win_sel_e   sel;
    logic       acc_wr, acc_rd;

    iwin_decode #(
        .HOST_AW  (HOST_AW),
        .PTR_OFS  (PTR_OFS),
        .PORT_OFS (PORT_OFS)
    ) u_decode (
        .host_addr (host_addr),
        .host_wr   (host_wr),
        .host_rd   (host_rd),
        .sel       (sel),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd)
    );

    iwin_route #(
        .HOST_AW     (HOST_AW),
        .INT_AW      (INT_AW),
        .DW          (DW),
        .DIRECT_BASE (DIRECT_BASE)
    ) u_route (
        .sel        (sel),
        .acc_wr     (acc_wr),
        .acc_rd     (acc_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .ptr        (st_q.ptr),
        .int_addr   (int_addr),
        .int_wdata  (int_wdata),
        .int_wr     (int_wr),
        .int_rd     (int_rd)
    );

    always_comb begin
        st_d = st_q;
        if (acc_wr && sel == SEL_PTR) begin
            st_d.ptr = {host_wdata[INT_AW-1:2], 2'b00};
        end
        if (acc_rd) begin
            case (sel)
                SEL_PTR:    st_d.rdata = {{RPAD{1'b0}}, st_q.ptr};
                SEL_PORT,
                SEL_DIRECT: st_d.rdata = int_rdata;
                default:    st_d.rdata = st_q.rdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;

endmodule

// File: rtl/iwin_chk.sv
module iwin_chk #(
    parameter int unsigned HOST_AW = 8,
    parameter int unsigned INT_AW  = 19,
    parameter int unsigned DW      = 32,
    parameter logic [HOST_AW-1:0] PTR_OFS  = 8'h40,
    parameter logic [HOST_AW-1:0] PORT_OFS = 8'h44
) (
    input logic               clk,
    input logic               rst_n,
    input logic [HOST_AW-1:0] host_addr,
    input logic [DW-1:0]      host_wdata,
    input logic               host_wr,
    input logic               host_rd,
    input logic [DW-1:0]      host_rdata,
    input logic [INT_AW-1:0]  int_addr,
    input logic [DW-1:0]      int_wdata,
    input logic               int_wr,
    input logic               int_rd,
    input logic [DW-1:0]      int_rdata
);

    localparam logic [HOST_AW-1:0] M = ~HOST_AW'(3);

    logic at_ptr, at_port, any_host;
    assign at_ptr   = (host_addr & M) == (PTR_OFS & M);
    assign at_port  = (host_addr & M) == (PORT_OFS & M);
    assign any_host = host_wr || host_rd;

    // R1: pointer accesses stay off the internal bus
    p_ptr_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (any_host && at_ptr) |-> (!int_wr && !int_rd));

    // R3: data-port write drives the written word out
    p_port_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && at_port) |-> (int_wr && int_wdata == host_wdata));

    // R4: read result appears one cycle later
    p_rd_return_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && !at_ptr) |=> (host_rdata == $past(int_rdata)));

    // R5: pointer write redirects the next data-port access
    p_redirect_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && at_ptr) |=>
            ((any_host && at_port) |-> (int_addr == {$past(host_wdata[INT_AW-1:2]), 2'b00})));

    // R6: internal addresses are word aligned
    p_align_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr || int_rd) |-> (int_addr[1:0] == 2'b00));

    // R7: read data holds without a read
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_rd && !host_wr) |=> $stable(host_rdata));

    // R8: a colliding read raises no internal read
    p_collide_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_rd) |-> !int_rd);

    // R10: strobes exclusive and never orphaned
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(int_wr && int_rd));
    p_orphan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr || int_rd) |-> any_host);

endmodule

bind iwin_top iwin_chk #(
    .HOST_AW  (HOST_AW),
    .INT_AW   (INT_AW),
    .DW       (DW),
    .PTR_OFS  (PTR_OFS),
    .PORT_OFS (PORT_OFS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_rdata (host_rdata),
    .int_addr   (int_addr),
    .int_wdata  (int_wdata),
    .int_wr     (int_wr),
    .int_rd     (int_rd),
    .int_rdata  (int_rdata)
);

// File: tb/iwin_top_tb.sv
`timescale 1ns/1ps
module iwin_top_tb;

    localparam logic [7:0]  PTR  = 8'h40;
    localparam logic [7:0]  PORT = 8'h44;
    localparam logic [18:0] BASE = 19'h50000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [31:0] host_rdata;
    logic [18:0] int_addr;
    logic [31:0] int_wdata;
    logic        int_wr, int_rd;
    logic [31:0] int_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // samples of the internal bus taken inside an access
    logic [18:0] s_addr;
    logic [31:0] s_wdata;
    logic        s_wr, s_rd;

    always #2.5 clk = ~clk;

    // internal register model: read value is a function of the address
    function automatic logic [31:0] model(input logic [18:0] a);
        return {13'h1A5F, a};
    endfunction
    assign int_rdata = model(int_addr);

    iwin_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .int_addr   (int_addr),
        .int_wdata  (int_wdata),
        .int_wr     (int_wr),
        .int_rd     (int_rd),
        .int_rdata  (int_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // one host cycle; starts and ends at a falling edge
    task automatic access(input logic wr, input logic rd, input logic [7:0] a, input logic [31:0] d);
        host_wr = wr; host_rd = rd; host_addr = a; host_wdata = d;
        #1;
        s_addr = int_addr; s_wdata = int_wdata; s_wr = int_wr; s_rd = int_rd;
        @(negedge clk);
        host_wr = 1'b0; host_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %h expected %h", 32'd0, 32'd1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [18:0] p;
        logic [31:0] held;
        @(negedge clk); @(negedge clk);
        // R2: reset state
        chk(host_rdata == 32'd0, "R2 rdata after reset", host_rdata, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 1'b1, PTR, 32'd0);
        chk(host_rdata == 32'd0, "R2 pointer after reset", host_rdata, 32'd0);
        chk(!s_wr && !s_rd, "R1 pointer read quiet", {30'd0, s_wr, s_rd}, 32'd0);

        // sweep pointer values: R1, R3, R4, R5, R9
        for (int k = 0; k < 96; k++) begin
            logic [31:0] wv;
            wv = {k[7:0] ^ 8'hC3, 5'h0, k[2:0], k[7:0] * 8'd37, k[7:0]};
            p  = {wv[18:2], 2'b00};
            access(1'b1, 1'b0, PTR + k[1:0], wv);
            chk(!s_wr && !s_rd, "R1 pointer write quiet", {30'd0, s_wr, s_rd}, 32'd0);
            // data-port write in the very next cycle (R5 redirect, R3)
            access(1'b1, 1'b0, PORT, ~wv);
            chk(s_wr && !s_rd, "R3 one write strobe", {30'd0, s_wr, s_rd}, 32'd2);
            chk(s_addr == p, "R5 redirect write addr", {13'd0, s_addr}, {13'd0, p});
            chk(s_wdata == ~wv, "R3 write data", s_wdata, ~wv);
            // data-port read (R4), pointer held (R5)
            access(1'b0, 1'b1, PORT, 32'd0);
            chk(s_rd && !s_wr && s_addr == p, "R4 read strobe addr", {13'd0, s_addr}, {13'd0, p});
            chk(host_rdata == model(p), "R4 read return", host_rdata, model(p));
            // pointer read back (R9, R1 bits 31:19 ignored)
            access(1'b0, 1'b1, PTR, 32'd0);
            chk(host_rdata == {13'd0, p}, "R9 pointer readback", host_rdata, {13'd0, p});
        end

        // R5: pointer survives many port accesses and idle time
        access(1'b1, 1'b0, PTR, 32'h0002_3454);
        for (int j = 0; j < 5; j++) access(1'b1, 1'b0, PORT, j);
        idle(3);
        access(1'b0, 1'b1, PORT, 32'd0);
        chk(s_addr == 19'h23454, "R5 pointer held", {13'd0, s_addr}, 32'h23454);

        // R6: direct offsets
        for (int a = 0; a < 256; a++) begin
            logic [7:0]  ha;
            logic [18:0] ea;
            ha = a[7:0];
            if ((ha & 8'hFC) == PTR || (ha & 8'hFC) == PORT) continue;
            ea = BASE + {11'd0, ha & 8'hFC};
            access(1'b0, 1'b1, ha, 32'd0);
            chk(s_rd && !s_wr && s_addr == ea, "R6 direct read addr", {13'd0, s_addr}, {13'd0, ea});
            chk(host_rdata == model(ea), "R6 direct read data", host_rdata, model(ea));
            access(1'b1, 1'b0, ha, {24'hD1EC70, ha});
            chk(s_wr && !s_rd && s_addr == ea && s_wdata == {24'hD1EC70, ha},
                "R6 direct write", s_wdata, {24'hD1EC70, ha});
        end

        // R7: rdata holds across writes and idle
        access(1'b0, 1'b1, PORT, 32'd0);
        held = host_rdata;
        access(1'b1, 1'b0, 8'h10, 32'hFFFF_FFFF);
        idle(4);
        access(1'b1, 1'b0, PTR, 32'h0000_1000);
        chk(host_rdata == held, "R7 rdata held", host_rdata, held);

        // R8: read and write together is a write only
        access(1'b1, 1'b1, PORT, 32'hA5A5_0001);
        chk(s_wr && !s_rd, "R8 collision strobes", {30'd0, s_wr, s_rd}, 32'd2);
        chk(host_rdata == held, "R8 rdata unchanged", host_rdata, held);
        access(1'b1, 1'b1, PTR, 32'h0000_2000);
        access(1'b0, 1'b1, PTR, 32'd0);
        chk(host_rdata == 32'h2000, "R8 collision pointer write", host_rdata, 32'h2000);

        // R10: no strobe while idle
        host_addr = PORT;
        #1;
        chk(!int_wr && !int_rd, "R10 idle quiet", {30'd0, int_wr, int_rd}, 32'd0);
        @(negedge clk);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule